// File: doc/BRIEF.md
# Multi-Port GPIO Controller

This block is a memory-mapped general-purpose I/O controller. It serves three plain bidirectional ports of 8, 24 and 13 pins. A fourth, mixed port combines 6 bidirectional pins, a 29-position input-only group and a 24-pin output-only group. Software uses a simple 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Writes take effect on the clock edge at which `bus_we` is high.

Output levels, directions and the port-2 alternate-function selects are never written directly. They change only through paired set and clear registers, and each one is read back through a separate state register. The mixed port does not have registers of its own:

- Its bidirectional pins keep their levels in the upper bits of the mixed-port output registers.
- Their direction bits sit in the upper bits of port 2's direction registers.
- Their inputs read back at scattered positions of the mixed-port input word.

Every pin input passes through a two-flop synchroniser before any register shows it.

Top module: `gpio_multiport`

## Requirements
- R1: After reset, all direction bits, output latches and alternate-function bits are 0, so every `*_oe`, `*_out` and `p2_alt` pin is low and every state register reads 0.
- R2: Writing a word to an output-set (0x44, 0x64, 0x20, 0x04), direction-set (0x50, 0x70, 0x10) or alternate-set (0x28) register forces to 1 the bits written as 1, starting on the next cycle.
- R3: Writing to the matching clear register (0x48, 0x68, 0x24, 0x08, 0x54, 0x74, 0x14, 0x2C) forces to 0 the bits written as 1. In any set or clear register, bits written as 0 leave the state unchanged.
- R4: A direction bit of 1 drives the matching `*_oe` pin high, meaning the pin is an output. Direction state reads back at 0x58 for port 0, 0x78 for port 1 and 0x18 for port 2.
- R5: The output latch updates while the pin is an input, and `*_out` always shows the latch. Setting the level before the direction therefore drives the new level from the first output cycle. Output state reads back at 0x4C for port 0 and 0x6C for port 1.
- R6: Write-data bits above a port's width are ignored, and those bits read back as 0.
- R7: Output-only pin n is controlled by bit n of 0x04/0x08. Mixed bidirectional pin n is controlled by bit 25+n of the same registers. Both groups read back at the same positions of 0x0C, and bit 24 and bit 31 read 0.
- R8: The direction of mixed bidirectional pin n is held at bit 25+n of the port-2 direction registers 0x10/0x14/0x18.
- R9: The mixed input word at 0x000 carries input-only position n at bit n. Bidirectional pins 0 to 4 appear at bits 10 to 14 and bidirectional pin 5 at bit 24, and the input-only positions 10 to 14 and 24 are ignored.
- R10: Input-state words (0x40, 0x60, 0x1C, 0x000) show a pin level two clock edges after it is sampled, and not after one.
- R11: Reads of an unmapped offset, including a misaligned one, return 0. Writes to an unmapped offset change no state.
- R12: The port-2 alternate-function select is a 13-bit set/clear register (0x28 set, 0x2C clear, 0x30 state) that drives `p2_alt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| p0_in | input | 8 | Port 0 pin inputs |
| p0_out | output | 8 | Port 0 output levels |
| p0_oe | output | 8 | Port 0 output enables |
| p1_in | input | 24 | Port 1 pin inputs |
| p1_out | output | 24 | Port 1 output levels |
| p1_oe | output | 24 | Port 1 output enables |
| p2_in | input | 13 | Port 2 pin inputs |
| p2_out | output | 13 | Port 2 output levels |
| p2_oe | output | 13 | Port 2 output enables |
| p2_alt | output | 13 | Port 2 alternate-function selects |
| p3io_in | input | 6 | Mixed-port bidirectional pin inputs |
| p3io_out | output | 6 | Mixed-port bidirectional output levels |
| p3io_oe | output | 6 | Mixed-port bidirectional output enables |
| p3i_in | input | 29 | Mixed-port input-only group |
| p3o_out | output | 24 | Mixed-port output-only levels |

## Verification
The assertions check several rules on every cycle:

- The set, clear and hold rules on the port-0 level and direction pins.
- The way a set write reaches the mixed-port bidirectional direction bits and the output-only pins.
- The two-edge latency from `p0_in` to its input word.
- The zero read of unmapped offsets.

Some behaviours only the bench scenarios can show:

- The scattered packing of the mixed input word, including the ignored input-only positions.
- The truncation of over-wide write data.
- The level-before-direction ordering.
- The port-2 alternate-function and direction readback.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Offsets that the checker and the bench refer to
    localparam logic [ADDR_W-1:0] OFS_P3_IN   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_P3_OSET = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_P2_DSET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_P0_IN   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_P0_OSET = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_P0_OCLR = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_P0_DSET = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_P0_DCLR = 8'h54;

    typedef enum logic [4:0] {
        RG_NONE,
        RG_P3_IN, RG_P3_OSET, RG_P3_OCLR, RG_P3_OST,
        RG_P2_DSET, RG_P2_DCLR, RG_P2_DST, RG_P2_IN,
        RG_P2_OSET, RG_P2_OCLR, RG_P2_MSET, RG_P2_MCLR, RG_P2_MST,
        RG_P0_IN, RG_P0_OSET, RG_P0_OCLR, RG_P0_OST,
        RG_P0_DSET, RG_P0_DCLR, RG_P0_DST,
        RG_P1_IN, RG_P1_OSET, RG_P1_OCLR, RG_P1_OST,
        RG_P1_DSET, RG_P1_DCLR, RG_P1_DST
    } reg_id_e;

    // Ports 0 and 1 share one bank layout; bit 5 of the address picks the bank
    function automatic reg_id_e decode_reg(input logic [ADDR_W-1:0] a);
        reg_id_e r;
        logic    hi;
        r  = RG_NONE;
        hi = a[5];
        if (a[7:6] == 2'b01) begin
            case (a[4:0])
                5'h00: r = hi ? RG_P1_IN   : RG_P0_IN;
                5'h04: r = hi ? RG_P1_OSET : RG_P0_OSET;
                5'h08: r = hi ? RG_P1_OCLR : RG_P0_OCLR;
                5'h0C: r = hi ? RG_P1_OST  : RG_P0_OST;
                5'h10: r = hi ? RG_P1_DSET : RG_P0_DSET;
                5'h14: r = hi ? RG_P1_DCLR : RG_P0_DCLR;
                5'h18: r = hi ? RG_P1_DST  : RG_P0_DST;
                default: r = RG_NONE;
            endcase
        end else if (a[7:6] == 2'b00) begin
            case (a[5:0])
                6'h00: r = RG_P3_IN;
                6'h04: r = RG_P3_OSET;
                6'h08: r = RG_P3_OCLR;
                6'h0C: r = RG_P3_OST;
                6'h10: r = RG_P2_DSET;
                6'h14: r = RG_P2_DCLR;
                6'h18: r = RG_P2_DST;
                6'h1C: r = RG_P2_IN;
                6'h20: r = RG_P2_OSET;
                6'h24: r = RG_P2_OCLR;
                6'h28: r = RG_P2_MSET;
                6'h2C: r = RG_P2_MCLR;
                6'h30: r = RG_P2_MST;
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sc_t;

    sc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) st_d.bits = st_d.bits | mask;
        if (clr_en) st_d.bits = st_d.bits & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;
endmodule

// File: rtl/gpio_multiport.sv
module gpio_multiport
    import gpio_mp_pkg::*;
#(
    parameter int P0_W    = 8,
    parameter int P1_W    = 24,
    parameter int P2_W    = 13,
    parameter int P3IO_W  = 6,
    parameter int P3I_W   = 29,
    parameter int P3O_W   = 24,
    parameter int IO_LSB  = 25,
    parameter int IO_IN_LO   = 10,
    parameter int IO_IN_LAST = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [P0_W-1:0]   p0_in,
    output logic [P0_W-1:0]   p0_out,
    output logic [P0_W-1:0]   p0_oe,
    input  logic [P1_W-1:0]   p1_in,
    output logic [P1_W-1:0]   p1_out,
    output logic [P1_W-1:0]   p1_oe,
    input  logic [P2_W-1:0]   p2_in,
    output logic [P2_W-1:0]   p2_out,
    output logic [P2_W-1:0]   p2_oe,
    output logic [P2_W-1:0]   p2_alt,
    input  logic [P3IO_W-1:0] p3io_in,
    output logic [P3IO_W-1:0] p3io_out,
    output logic [P3IO_W-1:0] p3io_oe,
    input  logic [P3I_W-1:0]  p3i_in,
    output logic [P3O_W-1:0]  p3o_out
);
    // Input-only positions that stay visible in the mixed input word
    function automatic logic [DATA_W-1:0] calc_gpi_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (b < P3I_W && !(b >= IO_IN_LO && b < IO_IN_LO + P3IO_W - 1) && b != IO_IN_LAST)
                m[b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] GPI_MASK = calc_gpi_mask();

    reg_id_e rid;
    logic    wdata_unused;

    assign rid          = decode_reg(bus_addr);
    assign wdata_unused = ^bus_wdata;

    function automatic logic hit(input reg_id_e r, input reg_id_e want, input logic we);
        return we && (r == want);
    endfunction

    // ---------------- input synchronisers ----------------
    logic [P0_W-1:0]   p0_s;
    logic [P1_W-1:0]   p1_s;
    logic [P2_W-1:0]   p2_s;
    logic [P3IO_W-1:0] p3io_s;
    logic [P3I_W-1:0]  p3i_s;

    gpio_sync2 #(.W(P0_W))   u_sy0  (.clk(clk), .rst_n(rst_n), .din(p0_in),   .dout(p0_s));
    gpio_sync2 #(.W(P1_W))   u_sy1  (.clk(clk), .rst_n(rst_n), .din(p1_in),   .dout(p1_s));
    gpio_sync2 #(.W(P2_W))   u_sy2  (.clk(clk), .rst_n(rst_n), .din(p2_in),   .dout(p2_s));
    gpio_sync2 #(.W(P3IO_W)) u_sy3b (.clk(clk), .rst_n(rst_n), .din(p3io_in), .dout(p3io_s));
    gpio_sync2 #(.W(P3I_W))  u_sy3i (.clk(clk), .rst_n(rst_n), .din(p3i_in),  .dout(p3i_s));

    // ---------------- plain ports 0 and 1 ----------------
    gpio_setclr #(.W(P0_W)) u_p0_lvl (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P0_OSET, bus_we)), .clr_en(hit(rid, RG_P0_OCLR, bus_we)),
        .mask(bus_wdata[P0_W-1:0]), .q(p0_out));
    gpio_setclr #(.W(P0_W)) u_p0_dir (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P0_DSET, bus_we)), .clr_en(hit(rid, RG_P0_DCLR, bus_we)),
        .mask(bus_wdata[P0_W-1:0]), .q(p0_oe));
    gpio_setclr #(.W(P1_W)) u_p1_lvl (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P1_OSET, bus_we)), .clr_en(hit(rid, RG_P1_OCLR, bus_we)),
        .mask(bus_wdata[P1_W-1:0]), .q(p1_out));
    gpio_setclr #(.W(P1_W)) u_p1_dir (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P1_DSET, bus_we)), .clr_en(hit(rid, RG_P1_DCLR, bus_we)),
        .mask(bus_wdata[P1_W-1:0]), .q(p1_oe));

    // ---------------- port 2 (also hosts mixed-port directions) ----------------
    gpio_setclr #(.W(P2_W)) u_p2_lvl (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P2_OSET, bus_we)), .clr_en(hit(rid, RG_P2_OCLR, bus_we)),
        .mask(bus_wdata[P2_W-1:0]), .q(p2_out));
    gpio_setclr #(.W(P2_W)) u_p2_dir (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P2_DSET, bus_we)), .clr_en(hit(rid, RG_P2_DCLR, bus_we)),
        .mask(bus_wdata[P2_W-1:0]), .q(p2_oe));
    gpio_setclr #(.W(P2_W)) u_p2_alt (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P2_MSET, bus_we)), .clr_en(hit(rid, RG_P2_MCLR, bus_we)),
        .mask(bus_wdata[P2_W-1:0]), .q(p2_alt));
    gpio_setclr #(.W(P3IO_W)) u_p3io_dir (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P2_DSET, bus_we)), .clr_en(hit(rid, RG_P2_DCLR, bus_we)),
        .mask(bus_wdata[IO_LSB +: P3IO_W]), .q(p3io_oe));

    // ---------------- mixed port levels ----------------
    gpio_setclr #(.W(P3O_W)) u_p3o_lvl (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P3_OSET, bus_we)), .clr_en(hit(rid, RG_P3_OCLR, bus_we)),
        .mask(bus_wdata[P3O_W-1:0]), .q(p3o_out));
    gpio_setclr #(.W(P3IO_W)) u_p3io_lvl (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit(rid, RG_P3_OSET, bus_we)), .clr_en(hit(rid, RG_P3_OCLR, bus_we)),
        .mask(bus_wdata[IO_LSB +: P3IO_W]), .q(p3io_out));

    // ---------------- mixed input word packing ----------------
    logic [DATA_W-1:0] p3_in_word;

    always_comb begin
        p3_in_word = DATA_W'(p3i_s) & GPI_MASK;
        for (int i = 0; i < P3IO_W - 1; i++) begin
            p3_in_word[IO_IN_LO + i] = p3io_s[i];
        end
        p3_in_word[IO_IN_LAST] = p3io_s[P3IO_W-1];
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        unique case (rid)
            RG_P3_IN:  bus_rdata = p3_in_word;
            RG_P3_OST: bus_rdata = DATA_W'(p3o_out) | (DATA_W'(p3io_out) << IO_LSB);
            RG_P2_DST: bus_rdata = DATA_W'(p2_oe) | (DATA_W'(p3io_oe) << IO_LSB);
            RG_P2_IN:  bus_rdata = DATA_W'(p2_s);
            RG_P2_MST: bus_rdata = DATA_W'(p2_alt);
            RG_P0_IN:  bus_rdata = DATA_W'(p0_s);
            RG_P0_OST: bus_rdata = DATA_W'(p0_out);
            RG_P0_DST: bus_rdata = DATA_W'(p0_oe);
            RG_P1_IN:  bus_rdata = DATA_W'(p1_s);
            RG_P1_OST: bus_rdata = DATA_W'(p1_out);
            RG_P1_DST: bus_rdata = DATA_W'(p1_oe);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mp_chk.sv
module gpio_mp_chk
    import gpio_mp_pkg::*;
#(
    parameter int P0_W   = 8,
    parameter int P3IO_W = 6,
    parameter int P3O_W  = 24,
    parameter int IO_LSB = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [P0_W-1:0]   p0_in,
    input logic [P0_W-1:0]   p0_out,
    input logic [P0_W-1:0]   p0_oe,
    input logic [P3IO_W-1:0] p3io_oe,
    input logic [P3O_W-1:0]  p3o_out
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    p0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_P0_OSET) |=>
        p0_out == ($past(p0_out) | $past(bus_wdata[P0_W-1:0])));

    // R3
    p0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_P0_OCLR) |=>
        p0_out == ($past(p0_out) & ~$past(bus_wdata[P0_W-1:0])));

    // R3
    p0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == OFS_P0_OSET || bus_addr == OFS_P0_OCLR)) |=> $stable(p0_out));

    // R4
    p0_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == OFS_P0_DSET || bus_addr == OFS_P0_DCLR)) |=> $stable(p0_oe));

    // R8
    p3io_dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_P2_DSET) |=>
        p3io_oe == ($past(p3io_oe) | $past(bus_wdata[IO_LSB +: P3IO_W])));

    // R7
    p3o_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_P3_OSET) |=>
        p3o_out == ($past(p3o_out) | $past(bus_wdata[P3O_W-1:0])));

    // R10
    p0_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && bus_addr == OFS_P0_IN) |->
        bus_rdata[P0_W-1:0] == $past(p0_in, 2));

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_reg(bus_addr) == RG_NONE) |-> bus_rdata == '0);
endmodule

bind gpio_multiport gpio_mp_chk #(
    .P0_W(P0_W), .P3IO_W(P3IO_W), .P3O_W(P3O_W), .IO_LSB(IO_LSB)
) u_chk (.*);

// File: tb/sim_gpio_multiport.sv
`timescale 1ns/1ps
module sim_gpio_multiport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  p0_in = '0;
    logic [7:0]  p0_out, p0_oe;
    logic [23:0] p1_in = '0;
    logic [23:0] p1_out, p1_oe;
    logic [12:0] p2_in = '0;
    logic [12:0] p2_out, p2_oe, p2_alt;
    logic [5:0]  p3io_in = '0;
    logic [5:0]  p3io_out, p3io_oe;
    logic [28:0] p3i_in = '0;
    logic [23:0] p3o_out;

    always #4 clk = ~clk;

    gpio_multiport u0 (.*);

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    function automatic logic [31:0] sample(input int k);
        case (k)
            0:  return bus_rdata;
            1:  return 32'(p0_out);
            2:  return 32'(p0_oe);
            3:  return 32'(p1_out);
            4:  return 32'(p1_oe);
            5:  return 32'(p2_out);
            6:  return 32'(p2_oe);
            7:  return 32'(p2_alt);
            8:  return 32'(p3io_out);
            9:  return 32'(p3io_oe);
            10: return 32'(p3o_out);
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // monitor: pops and compares two time units after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = q.pop_front();
                got = sample(it.kind);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                             it.req, it.kind, bus_addr, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk(input int k, input logic [7:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        q.push_back('{k, e, r});
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(0, 8'h4C, 32'h0, "R1 p0 out state");
        chk(0, 8'h58, 32'h0, "R1 p0 dir state");
        chk(0, 8'h0C, 32'h0, "R1 p3 out state");
        chk(0, 8'h18, 32'h0, "R1 p2 dir state");
        chk(0, 8'h30, 32'h0, "R1 alt state");
        chk(0, 8'h40, 32'h0, "R1 p0 input");
        chk(10, 8'h00, 32'h0, "R1 output-only pins");
        chk(4, 8'h00, 32'h0, "R1 p1 oe");

        // R2 R5 level set while input
        wr(8'h44, 32'h0000_00A5);
        chk(0, 8'h4C, 32'hA5, "R2 p0 out state");
        chk(1, 8'h4C, 32'hA5, "R5 p0 pins follow latch");
        chk(2, 8'h4C, 32'h00, "R5 p0 still input");
        // R3 clear and zero bits
        wr(8'h48, 32'h0000_000F);
        chk(1, 8'h4C, 32'hA0, "R3 p0 clear");
        wr(8'h44, 32'h0000_0000);
        chk(0, 8'h4C, 32'hA0, "R3 zero set bits no effect");
        // R4 direction
        wr(8'h50, 32'h0000_00F0);
        chk(2, 8'h58, 32'hF0, "R4 p0 oe set");
        wr(8'h54, 32'h0000_0030);
        chk(0, 8'h58, 32'hC0, "R4 p0 dir state");
        chk(1, 8'h58, 32'hA0, "R5 level kept after dir change");

        // R6 port 1 truncation
        wr(8'h64, 32'hFFFF_FFFF);
        chk(0, 8'h6C, 32'h00FF_FFFF, "R6 p1 out state");
        chk(3, 8'h6C, 32'h00FF_FFFF, "R6 p1 pins");
        wr(8'h70, 32'h0080_0001);
        chk(0, 8'h78, 32'h0080_0001, "R4 p1 dir state");

        // port 2
        wr(8'h20, 32'hFFFF_FFFF);
        chk(5, 8'h00, 32'h0000_1FFF, "R6 p2 pins");
        wr(8'h10, 32'h0000_1001);
        chk(6, 8'h18, 32'h0000_1001, "R4 p2 oe");
        chk(9, 8'h18, 32'h0, "R8 p3io oe untouched");
        wr(8'h10, 32'h4200_0000);
        chk(9, 8'h18, 32'h21, "R8 p3io oe");
        chk(0, 8'h18, 32'h4200_1001, "R8 p2 dir state packing");
        wr(8'h14, 32'h0200_0000);
        chk(9, 8'h18, 32'h20, "R8 p3io dir clear");

        // R7 mixed outputs
        wr(8'h04, 32'hFF00_0003);
        chk(8, 8'h0C, 32'h3F, "R7 p3io levels");
        chk(10, 8'h0C, 32'h3, "R7 output-only levels");
        chk(0, 8'h0C, 32'h7E00_0003, "R7 out state packing");
        wr(8'h08, 32'h0400_0001);
        chk(0, 8'h0C, 32'h7A00_0002, "R7 clear");
        chk(8, 8'h0C, 32'h3D, "R7 p3io after clear");

        // R12 alternate function
        wr(8'h28, 32'h0000_0105);
        chk(7, 8'h30, 32'h105, "R12 alt pins");
        wr(8'h2C, 32'h0000_0004);
        chk(0, 8'h30, 32'h101, "R12 alt state");

        // R9 mixed input packing
        @(negedge clk);
        p3i_in = 29'h1FFF_FFFF; p3io_in = 6'b100101;
        p2_in = 13'h1ABC; p0_in = 8'h3C; p1_in = 24'h12_3456;
        settle();
        chk(0, 8'h00, 32'h1FFF_97FF, "R9 mixed input word");
        chk(0, 8'h1C, 32'h0000_1ABC, "R10 p2 input");
        chk(0, 8'h60, 32'h0012_3456, "R10 p1 input");
        @(negedge clk);
        p3i_in = 29'h0100_7C00; p3io_in = 6'b000000;
        settle();
        chk(0, 8'h00, 32'h0, "R9 shared positions ignored");

        // R10 two-edge latency
        @(negedge clk);
        p0_in = 8'h55; bus_addr = 8'h40; bus_we = 1'b0;
        q.push_back('{0, 32'h3C, "R10 not after one edge"});
        @(negedge clk);
        q.push_back('{0, 32'h55, "R10 after two edges"});
        @(negedge clk);

        // R11 unmapped
        chk(0, 8'h34, 32'h0, "R11 unmapped 0x34");
        chk(0, 8'h7C, 32'h0, "R11 unmapped 0x7C");
        chk(0, 8'h41, 32'h0, "R11 misaligned");
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h45, 32'hFFFF_FFFF);
        chk(1, 8'h4C, 32'hA0, "R11 write ignored p0 pins");
        chk(2, 8'h4C, 32'hC0, "R11 write ignored p0 oe");
        chk(0, 8'h0C, 32'h7A00_0002, "R11 write ignored p3");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule